// File: doc/BRIEF.md
# Stride Reference Prediction Table

This block watches the stream of data memory references that a processor core makes, one reference per accepted transfer, each tagged with the program counter of the load or store that made it. It keeps a direct-mapped table indexed by the program counter. Each entry holds a tag, the address last referenced by that instruction, a learned stride and a two-bit confidence state. On each reference it checks whether the address equals the previous address plus the stride. It then updates the entry and may produce a prefetch candidate at the current address plus the stride held after the update.

A candidate does not leave the block unfiltered. In the cycle it forms, the candidate is shown on a tag-probe port to the first-level cache, and a hit there drops it. It is also dropped when a copy of its cache line is already outstanding, or when the eight-slot outstanding-request list has no free slot. A surviving candidate is placed in a one-entry output register and takes a list slot. That slot is released when the memory system signals a fill for the same line.

References enter on a valid/ready stream. The block accepts a reference only when its prefetch output register is empty or is being emptied in that same cycle, so a stalled prefetch consumer holds back the reference stream. Prefetch requests leave on a valid/ready stream. Fill notices arrive on a stream whose ready is always high.

Top module: `stride_rpt`

## Requirements
- R1: After reset no prefetch is offered (pf_valid low), acc_ready is high, and every table entry is empty, so the first reference of any instruction allocates an entry and makes no prefetch.
- R2: The table is direct-mapped. The index is acc_pc[PC_LSB+IDX_W-1:PC_LSB] and the tag is the pc bits above it. A reference whose index holds no entry, or holds an entry with another tag, writes a fresh entry: confidence init, stride 0, last address set to the reference address. It makes no prefetch, and any older entry at that index is lost.
- R3: A reference to a live entry counts as correct when its address equals last address plus stride, modulo 2^ADDR_W. The last address is always overwritten with the reference address. A "new stride" is the reference address minus the old last address.
- R4: From init, a correct reference moves to steady and keeps the stride; an incorrect one moves to transient and takes the new stride.
- R5: In steady, a correct reference stays in steady; an incorrect one returns to init and keeps the old stride.
- R6: From transient, a correct reference moves to steady; an incorrect one moves to no-prediction and takes the new stride.
- R7: In no-prediction, a correct reference moves to transient; an incorrect one stays in no-prediction and takes the new stride.
- R8: A reference to a live entry forms a candidate at reference address plus the stride held after the update, unless the state after the update is no-prediction. The prefetch appears on pf_valid/pf_addr in the cycle after the reference is accepted.
- R9: A candidate is driven on l1_probe_addr with l1_probe_valid high in the cycle of acceptance; if l1_probe_hit is high in that cycle the candidate is dropped.
- R10: A candidate whose line (address bits above LINE_OFF) equals that of any outstanding request is dropped. A fill arriving in the same cycle does not yet release its line for this comparison.
- R11: The outstanding list holds ORL_DEPTH (8) lines. A prefetch takes a slot when it enters the output register and keeps it until a fill with the same line is accepted. A candidate met by a full list is dropped. fill_ready is always high.
- R12: pf_valid and pf_addr stay unchanged until pf_ready is high. acc_ready is high exactly when pf_valid is low or pf_ready is high, and a reference is accepted when acc_valid and acc_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A memory reference is offered |
| acc_ready | output | 1 | The block accepts the offered reference |
| acc_pc | input | PC_W | Program counter of the referencing instruction |
| acc_addr | input | ADDR_W | Data address of the reference |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the prefetch request |
| pf_addr | output | ADDR_W | Prefetch address |
| l1_probe_valid | output | 1 | A candidate is being checked against cache tags |
| l1_probe_addr | output | ADDR_W | Candidate address for the tag check |
| l1_probe_hit | input | 1 | The candidate line is already cached (same cycle) |
| fill_valid | input | 1 | A prefetched line has returned |
| fill_ready | output | 1 | Always high |
| fill_addr | input | ADDR_W | Address of the returned line |

## Verification
A wrong confidence state or stride stays hidden until the next reference by the same instruction. It then shows up one cycle after that reference as a missing prefetch, a surplus prefetch or a wrong pf_addr. A stale or lost slot in the outstanding list shows only when a later candidate in the same line is wrongly dropped or wrongly issued, or when the list reports full too early or too late. That can be many references later. The bench therefore steers each confidence transition with short directed sequences that expose the stride on the very next access. It fills and drains the list on purpose, and it compares every port against a behavioural model on every clock through a long mixed run.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [1:0] {
    CONF_INIT   = 2'd0,
    CONF_TRANS  = 2'd1,
    CONF_STEADY = 2'd2,
    CONF_NOPRED = 2'd3
  } conf_e;
endpackage

// File: rtl/rpt_conf_fsm.sv
module rpt_conf_fsm
  import rpt_pkg::*;
(
  input  conf_e cur_state,
  input  logic  correct,
  output conf_e nxt_state,
  output logic  take_stride
);
  always_comb begin
    nxt_state   = cur_state;
    take_stride = 1'b0;
    unique case (cur_state)
      CONF_INIT: begin
        nxt_state   = correct ? CONF_STEADY : CONF_TRANS;
        take_stride = !correct;
      end
      CONF_STEADY: begin
        nxt_state   = correct ? CONF_STEADY : CONF_INIT;
        take_stride = 1'b0;
      end
      CONF_TRANS: begin
        nxt_state   = correct ? CONF_STEADY : CONF_NOPRED;
        take_stride = !correct;
      end
      CONF_NOPRED: begin
        nxt_state   = correct ? CONF_TRANS : CONF_NOPRED;
        take_stride = !correct;
      end
      default: begin
        nxt_state   = CONF_INIT;
        take_stride = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rpt_table.sv
module rpt_table
  import rpt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 512,
  parameter int PC_LSB  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              cand_valid,
  output logic [ADDR_W-1:0] cand_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - PC_LSB;

  logic [ENTRIES-1:0] live_q;
  logic [TAG_W-1:0]   tag_mem    [ENTRIES];
  logic [ADDR_W-1:0]  last_mem   [ENTRIES];
  logic [ADDR_W-1:0]  stride_mem [ENTRIES];
  conf_e              conf_mem   [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] last_rd, stride_rd, guess, delta, stride_nx;
  conf_e             conf_rd, conf_nx;
  logic              correct, take_stride;

  assign idx       = lk_pc[PC_LSB +: IDX_W];
  assign tag       = lk_pc[PC_LSB+IDX_W +: TAG_W];
  assign last_rd   = last_mem[idx];
  assign stride_rd = stride_mem[idx];
  assign conf_rd   = conf_mem[idx];
  assign lk_hit    = live_q[idx] && (tag_mem[idx] == tag);
  assign guess     = last_rd + stride_rd;
  assign delta     = lk_addr - last_rd;
  assign correct   = (lk_addr == guess);

  rpt_conf_fsm u_fsm (
    .cur_state  (conf_rd),
    .correct    (correct),
    .nxt_state  (conf_nx),
    .take_stride(take_stride)
  );

  assign stride_nx  = take_stride ? delta : stride_rd;
  assign cand_valid = lk_en && lk_hit && (conf_nx != CONF_NOPRED);
  assign cand_addr  = lk_addr + stride_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (lk_en) begin
      live_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_en) begin
      tag_mem[idx]  <= tag;
      last_mem[idx] <= lk_addr;
      if (lk_hit) begin
        stride_mem[idx] <= stride_nx;
        conf_mem[idx]   <= conf_nx;
      end else begin
        stride_mem[idx] <= '0;
        conf_mem[idx]   <= CONF_INIT;
      end
    end
  end

  // R7 / R8: a wrong guess seen in no-prediction never yields a candidate
  a_r7_nopred_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_hit && conf_rd == CONF_NOPRED && !correct) |-> !cand_valid);

  // R5: a miss in steady keeps the old stride, so the candidate uses it
  a_r5_steady_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_hit && conf_rd == CONF_STEADY) |-> (cand_valid && cand_addr == lk_addr + stride_rd));
endmodule

// File: rtl/rpt_orl.sv
module rpt_orl #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] q_line,
  input  logic              alloc,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  output logic              dup,
  output logic              full
);
  logic [DEPTH-1:0]  busy_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0]  match_vec, drop_vec, pick;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign match_vec[i] = busy_q[i] && (line_q[i] == q_line);
    assign drop_vec[i]  = fill_valid && busy_q[i] && (line_q[i] == fill_line);

    always_ff @(posedge clk) begin
      if (alloc && pick[i]) line_q[i] <= q_line;
    end
  end

  always_comb begin
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign dup  = |match_vec;
  assign full = &busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~drop_vec) | (alloc ? pick : '0);
  end

  // R11: no slot is taken while the list is full
  a_r11_alloc_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  // R10: a line is never entered twice
  a_r10_alloc_unique: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !dup);
  // R11: an allocation grows the occupancy unless a fill releases a slot
  a_r11_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !fill_valid) |=> $countones(busy_q) == $countones($past(busy_q)) + 1);
endmodule

// File: rtl/stride_rpt.sv
module stride_rpt
  import rpt_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 512,
  parameter int PC_LSB    = 2,
  parameter int LINE_OFF  = 6,
  parameter int ORL_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              l1_probe_valid,
  output logic [ADDR_W-1:0] l1_probe_addr,
  input  logic              l1_probe_hit,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr
);
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic              acc_fire, tbl_hit, cand_valid, issue, orl_dup, orl_full;
  logic [ADDR_W-1:0] cand_addr;
  logic              unused_low;

  assign unused_low = ^{acc_pc[PC_LSB-1:0], fill_addr[LINE_OFF-1:0], cand_addr[LINE_OFF-1:0]};

  assign acc_ready = !pf_valid || pf_ready;
  assign acc_fire  = acc_valid && acc_ready;
  assign fill_ready = 1'b1;

  rpt_table #(
    .PC_W   (PC_W),
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .PC_LSB (PC_LSB)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_en     (acc_fire),
    .lk_pc     (acc_pc),
    .lk_addr   (acc_addr),
    .lk_hit    (tbl_hit),
    .cand_valid(cand_valid),
    .cand_addr (cand_addr)
  );

  assign l1_probe_valid = cand_valid;
  assign l1_probe_addr  = cand_addr;

  rpt_orl #(
    .DEPTH (ORL_DEPTH),
    .LINE_W(LINE_W)
  ) u_orl (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_line    (cand_addr[ADDR_W-1:LINE_OFF]),
    .alloc     (issue),
    .fill_valid(fill_valid && fill_ready),
    .fill_line (fill_addr[ADDR_W-1:LINE_OFF]),
    .dup       (orl_dup),
    .full      (orl_full)
  );

  assign issue = cand_valid && !l1_probe_hit && !orl_dup && !orl_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (issue) begin
      pf_valid <= 1'b1;
      pf_addr  <= cand_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R12: an offered prefetch holds until taken
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));
  // R9: a cache hit on the probe leaves the output empty
  a_r9_l1_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_probe_valid && l1_probe_hit) |=> !pf_valid);
  // R2: an allocating reference produces no prefetch
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !tbl_hit) |=> !pf_valid);
endmodule

// File: tb/stride_rpt_test.sv
module stride_rpt_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, pf_ready = 1'b1, fill_valid = 1'b0;
  logic [31:0] acc_pc = '0, acc_addr = '0, fill_addr = '0;
  logic        acc_ready, pf_valid, l1_probe_valid, l1_probe_hit, fill_ready;
  logic [31:0] pf_addr, l1_probe_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit l1_has(logic [31:0] a);
    return a[15:12] == 4'hE;
  endfunction

  assign l1_probe_hit = l1_probe_valid && l1_has(l1_probe_addr);

  stride_rpt uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .l1_probe_valid(l1_probe_valid), .l1_probe_addr(l1_probe_addr), .l1_probe_hit(l1_probe_hit),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr)
  );

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";

  // behavioural model: 0 init, 1 transient, 2 steady, 3 no-prediction
  bit          m_live [512];
  logic [20:0] m_tag  [512];
  logic [31:0] m_last [512];
  logic [31:0] m_str  [512];
  int          m_conf [512];
  logic [25:0] m_orl[$];
  bit          m_pfv = 0;
  logic [31:0] m_pfa = '0;
  logic [31:0] fq_addr[$];
  int          fq_due[$];
  bit          fill_en = 1;
  int          fill_dly = 2;
  bit          accepted;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    bit m_ready, cand, dup, load;
    logic [31:0] caddr;
    int idx;
    fill_valid = 0;
    fill_addr  = '0;
    if (fill_en && fq_addr.size() > 0 && fq_due[0] <= cyc) begin
      fill_valid = 1;
      fill_addr  = fq_addr[0];
    end
    #1;
    m_ready = !m_pfv || pf_ready;
    checks++;
    if (acc_ready !== m_ready || pf_valid !== m_pfv || (m_pfv && pf_addr !== m_pfa)) begin
      errors++;
      $display("FAIL %s cycle %0d: actual v=%b a=%h rdy=%b expected v=%b a=%h rdy=%b",
               phase, cyc, pf_valid, pf_addr, acc_ready, m_pfv, m_pfa, m_ready);
    end
    accepted = acc_valid && m_ready;
    cand = 0; caddr = '0; load = 0;
    if (accepted) begin
      idx = int'(acc_pc[10:2]);
      if (m_live[idx] && m_tag[idx] == acc_pc[31:11]) begin
        bit ok;
        logic [31:0] d;
        ok = (acc_addr == m_last[idx] + m_str[idx]);
        d  = acc_addr - m_last[idx];
        case (m_conf[idx])
          0: begin m_conf[idx] = ok ? 2 : 1; if (!ok) m_str[idx] = d; end
          2: begin m_conf[idx] = ok ? 2 : 0; end
          1: begin m_conf[idx] = ok ? 2 : 3; if (!ok) m_str[idx] = d; end
          default: begin m_conf[idx] = ok ? 1 : 3; if (!ok) m_str[idx] = d; end
        endcase
        m_last[idx] = acc_addr;
        if (m_conf[idx] != 3) begin cand = 1; caddr = acc_addr + m_str[idx]; end
      end else begin
        m_live[idx] = 1; m_tag[idx] = acc_pc[31:11];
        m_last[idx] = acc_addr; m_str[idx] = 0; m_conf[idx] = 0;
      end
    end
    if (cand) begin
      dup = 0;
      foreach (m_orl[i]) if (m_orl[i] == caddr[31:6]) dup = 1;
      load = !l1_has(caddr) && !dup && m_orl.size() < 8;
    end
    @(posedge clk);
    if (m_pfv && pf_ready) begin
      fq_addr.push_back(m_pfa);
      fq_due.push_back(cyc + fill_dly);
    end
    if (fill_valid) begin
      for (int i = 0; i < m_orl.size(); i++)
        if (m_orl[i] == fill_addr[31:6]) begin m_orl.delete(i); break; end
      void'(fq_addr.pop_front());
      void'(fq_due.pop_front());
    end
    if (load) begin
      m_pfv = 1; m_pfa = caddr;
      m_orl.push_back(caddr[31:6]);
    end else if (pf_ready) begin
      m_pfv = 0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic acc(logic [31:0] pc, logic [31:0] addr);
    acc_valid = 1; acc_pc = pc; acc_addr = addr;
    do step(); while (!accepted);
    acc_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    logic [31:0] spc [6];
    logic [31:0] snx [6];
    logic [31:0] sst [6];
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(pf_valid == 0, "R1 reset pf_valid", {31'd0, pf_valid}, 0);
    chk(acc_ready == 1, "R1 reset acc_ready", {31'd0, acc_ready}, 1);
    chk(fill_ready == 1, "R11 fill_ready", {31'd0, fill_ready}, 1);
    idle(2);

    // state walk on one instruction
    phase = "R2,R3,R4";
    acc(32'h1000, 32'h100);
    chk(pf_valid == 0, "R2 allocation silent", {31'd0, pf_valid}, 0);
    acc(32'h1000, 32'h140);
    chk(pf_valid && pf_addr == 32'h180, "R4 init wrong -> transient", pf_addr, 32'h180);
    idle(3);
    phase = "R6,R8";
    acc(32'h1000, 32'h180);
    chk(pf_valid && pf_addr == 32'h1C0, "R6 transient right -> steady", pf_addr, 32'h1C0);
    idle(3);
    acc(32'h1000, 32'h1C0); idle(3);
    phase = "R5";
    acc(32'h1000, 32'h300);
    chk(pf_valid && pf_addr == 32'h340, "R5 steady wrong keeps stride", pf_addr, 32'h340);
    idle(3);
    phase = "R4";
    acc(32'h1000, 32'h340);
    chk(pf_valid && pf_addr == 32'h380, "R4 init right -> steady", pf_addr, 32'h380);
    idle(3);
    acc(32'h1000, 32'h500); idle(3);
    acc(32'h1000, 32'h520); idle(3);
    phase = "R6,R7";
    acc(32'h1000, 32'h600);
    chk(pf_valid == 0, "R6 transient wrong -> no-prediction", {31'd0, pf_valid}, 0);
    acc(32'h1000, 32'h700);
    chk(pf_valid == 0, "R7 no-prediction wrong stays", {31'd0, pf_valid}, 0);
    acc(32'h1000, 32'h800);
    chk(pf_valid && pf_addr == 32'h900, "R7 no-prediction right -> transient", pf_addr, 32'h900);
    idle(3);
    phase = "R3";
    acc(32'h1000, 32'h900);
    chk(pf_valid && pf_addr == 32'hA00, "R3 last address tracked", pf_addr, 32'hA00);
    idle(3);

    // replacement at a shared index
    phase = "R2";
    acc(32'h1800, 32'h4000);
    chk(pf_valid == 0, "R2 other tag allocates", {31'd0, pf_valid}, 0);
    acc(32'h1000, 32'hA00);
    chk(pf_valid == 0, "R2 evicted entry re-allocates", {31'd0, pf_valid}, 0);
    idle(3);

    // cache tag filter
    phase = "R9";
    acc(32'h2004, 32'hE000);
    acc(32'h2004, 32'hE040);
    chk(pf_valid == 0, "R9 cached line dropped", {31'd0, pf_valid}, 0);
    acc(32'h2004, 32'hE080);
    chk(pf_valid == 0, "R9 cached line dropped", {31'd0, pf_valid}, 0);
    idle(2);

    // duplicate filter, fills held back
    phase = "R10";
    idle(6);
    fill_en = 0;
    acc(32'h3008, 32'h2000);
    acc(32'h3008, 32'h2000);
    chk(pf_valid && pf_addr == 32'h2000, "R10 first copy issued", pf_addr, 32'h2000);
    acc(32'h3008, 32'h2000);
    chk(pf_valid == 0, "R10 same line dropped", {31'd0, pf_valid}, 0);
    acc(32'h300C, 32'h3000);
    acc(32'h300C, 32'h3008);
    acc(32'h300C, 32'h3010);
    chk(pf_valid == 0, "R10 same line other offset dropped", {31'd0, pf_valid}, 0);

    // full list
    phase = "R11";
    for (int k = 0; k < 8; k++) begin
      acc(32'h5000_0000 + 32'(k) * 4, 32'h20000 + 32'(k) * 32'h1000);
      acc(32'h5000_0000 + 32'(k) * 4, 32'h20100 + 32'(k) * 32'h1000);
    end
    chk(pf_valid == 0, "R11 full list drops", {31'd0, pf_valid}, 0);
    fill_en = 1;
    idle(20);
    acc(32'h6000, 32'h40000);
    acc(32'h6000, 32'h40100);
    chk(pf_valid && pf_addr == 32'h40200, "R11 slots released by fills", pf_addr, 32'h40200);
    idle(4);

    // back-pressure
    phase = "R12";
    pf_ready = 0;
    acc(32'h7000, 32'h50000);
    acc(32'h7000, 32'h50040);
    held = pf_addr;
    acc_valid = 1; acc_pc = 32'h7000; acc_addr = 32'h50080;
    idle(4);
    chk(acc_ready == 0, "R12 stalled output blocks references", {31'd0, acc_ready}, 0);
    chk(pf_valid && pf_addr == held, "R12 held prefetch", pf_addr, held);
    pf_ready = 1;
    do step(); while (!accepted);
    acc_valid = 0;
    idle(4);

    // mixed run
    phase = "R3,R8,R10,R12 mixed";
    for (int k = 0; k < 6; k++) begin
      spc[k] = 32'h8000_0000 + 32'(k) * 32'h44;
      snx[k] = 32'h0010_0000 * 32'(k + 1);
      sst[k] = 32'(k % 3 + 1) * 32'h40;
    end
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = int'($urandom % 6);
      acc_valid = ($urandom % 10) < 7;
      pf_ready  = ($urandom % 4) != 0;
      fill_dly  = 1 + int'($urandom % 6);
      acc_pc    = spc[k];
      acc_addr  = (($urandom % 8) == 0) ? ($urandom & 32'hFFFF_FFC0) : snx[k];
      step();
      if (accepted) snx[k] = acc_addr + sst[k];
    end
    acc_valid = 0;
    pf_ready  = 1;
    idle(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule